// File: doc/BRIEF.md
# I2C Master with Acknowledge Polling

This block is a single-master I2C bus engine. A host issues one command at a time and the block turns it into a sequence of line changes on open-drain clock and data pads. There are five commands: a start condition, a stop condition, sending one byte and reading back the target's acknowledge, receiving one byte and returning a chosen acknowledge bit, and a polling command. The host builds whole transfers out of these commands. For example, a memory read is a poll on the write address, one or two offset bytes, a start, the read address, several byte reads and a stop.

The polling command is meant for serial memories that ignore their address while an internal write cycle is running. It sends a start condition and the address byte. If the address is not acknowledged, it sends the pair again, with no stop condition in between. It ends when an acknowledge arrives or after `POLL_MAX` attempts, and in the second case it raises a timeout flag.

Every line change is held for a programmable number of half-microsecond units. The same logic therefore serves both standard-speed and fast targets. A typical setting is 10 units for standard speed and 3 units for fast mode. The pads are driven active-low through output enables. The data pad is read back through a two-flop synchroniser.

Top module: `i2c_poll_master`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `done` are 0 and both output enables are 0, so both lines are released.
- R2: Command code 1 (start) makes three line changes, ending with both lines driven low. The data line falls while the clock line is high.
- R3: Command code 2 (stop) makes three line changes, ending with both lines released. The data line rises while the clock line is high.
- R4: Command code 3 (write) sends `cmd_data` most significant bit first, as eight clock pulses followed by a ninth acknowledge pulse. The data line changes only while the clock line is low.
- R5: After a write, `nack` is 0 if the data line was low during the ninth clock-high phase and 1 if it was high.
- R6: Command code 4 (read) assembles eight sampled bits most significant bit first into `rx_data`. In the ninth clock pulse the block drives the value of `cmd_ack` (0 acknowledges, 1 does not).
- R7: Command code 5 (poll) repeats a start condition plus the address byte in `cmd_data`, with no stop between attempts, until an acknowledge arrives. Each attempt is 30 steps long.
- R8: If `POLL_MAX` attempts all go unacknowledged, the poll ends with `timeout`=1 and `nack`=1. Every accepted command clears `timeout`.
- R9: Each step lasts max(`dly_units`,1) times `CYC_PER_UNIT` clock cycles. A start or stop is 3 steps long, and a write or read is 27 steps long.
- R10: `busy` is high from the cycle after a command is accepted until it completes. Commands that arrive while busy, and command codes 0, 6 and 7 at any time, have no effect.
- R11: `done` is a single-cycle pulse in the cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 3 | Command code (1 start, 2 stop, 3 write, 4 read, 5 poll) |
| cmd_data | input | 8 | Byte to send, or the poll address |
| cmd_ack | input | 1 | Acknowledge bit the block drives after a read |
| dly_units | input | UNIT_W | Step length in half-microsecond units |
| sda_in | input | 1 | Data pad level |
| scl_oe | output | 1 | Clock pad pull-low enable |
| sda_oe | output | 1 | Data pad pull-low enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| rx_data | output | 8 | Last received byte |
| nack | output | 1 | Last acknowledge slot read high |
| timeout | output | 1 | Poll gave up |

## Verification
Let S be the step length, max(`dly_units`,1) times `CYC_PER_UNIT`, counted from the edge at which the command is accepted. Then `done` rises exactly N·S cycles after that edge, where N is 3 for a start or stop, 27 for a write or read, and 30 times the number of attempts for a poll. The bench counts rising edges from the accept edge and samples `done`, `nack`, `rx_data` and the line states half a cycle after each edge. A timing check therefore fails if a result arrives a single edge early or late. A bus-side target model records the bits it sees, the number of start conditions and the master's acknowledge bit, so the poll retry count and the bit order are checked on the wires rather than inside the block.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4,
    OP_POLL  = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_STOP, S_WBIT, S_ACKRD, S_RBIT, S_RACK
  } st_e;

  // line levels {scl, sda} for a step; 1 means released
  function automatic logic [1:0] step_lines(st_e st, logic [1:0] step, logic b, logic a);
    logic [1:0] r;
    case (st)
      S_START: r = {step != 2'd2, step == 2'd0};
      S_STOP:  r = {step != 2'd0, step == 2'd2};
      S_WBIT:  r = {step == 2'd1, b};
      S_RACK:  r = {step == 2'd1, a};
      default: r = {step == 2'd1, 1'b1};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cm_delay.sv
module i2cm_delay #(
  parameter int CYC_PER_UNIT = 25,
  parameter int UNIT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [UNIT_W-1:0] units,
  output logic              tick
);
  localparam int SUB_W = (CYC_PER_UNIT > 1) ? $clog2(CYC_PER_UNIT) : 1;
  localparam logic [SUB_W-1:0] SUB_LOAD = SUB_W'(CYC_PER_UNIT - 1);

  logic [SUB_W-1:0]  sub;
  logic [UNIT_W-1:0] unit;
  logic              run;

  assign tick = run && (sub == '0) && (unit == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      sub  <= '0;
      unit <= '0;
    end else if (start) begin
      run  <= 1'b1;
      sub  <= SUB_LOAD;
      unit <= (units == '0) ? '0 : units - 1'b1;
    end else if (run) begin
      if (sub == '0) begin
        sub <= SUB_LOAD;
        if (unit == '0) run <= 1'b0;
        else            unit <= unit - 1'b1;
      end else begin
        sub <= sub - 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int POLL_MAX = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_ack,
  input  logic       tick,
  input  logic       sda_s,
  output logic       dly_start,
  output logic       scl_rel,
  output logic       sda_rel,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       nack,
  output logic       timeout,
  output logic       in_data
);
  localparam int TRY_W = $clog2(POLL_MAX + 1);

  st_e              st, st_n;
  logic [1:0]       step, step_n;
  logic [2:0]       bitn, bitn_n;
  logic [7:0]       sh, sh_n, addr, addr_n, rx_n;
  logic             poll, poll_n, mack, mack_n;
  logic             nack_n, to_n, done_n, adv;
  logic [TRY_W-1:0] tries, tries_n;

  always_comb begin
    st_n = st; step_n = step; bitn_n = bitn; sh_n = sh; addr_n = addr;
    poll_n = poll; mack_n = mack; nack_n = nack; to_n = timeout;
    rx_n = rx_data; tries_n = tries; done_n = 1'b0; adv = 1'b0;
    if (st == S_IDLE) begin
      if (cmd_valid) begin
        adv = 1'b1; step_n = 2'd0; bitn_n = 3'd0; poll_n = 1'b0; to_n = 1'b0;
        case (op_e'(cmd_op))
          OP_START: st_n = S_START;
          OP_STOP:  st_n = S_STOP;
          OP_WRITE: begin st_n = S_WBIT; sh_n = cmd_data; end
          OP_READ:  begin st_n = S_RBIT; mack_n = cmd_ack; end
          OP_POLL:  begin st_n = S_START; poll_n = 1'b1; addr_n = cmd_data; tries_n = TRY_W'(1); end
          default:  begin adv = 1'b0; to_n = timeout; poll_n = poll; end
        endcase
      end
    end else if (tick) begin
      adv = 1'b1;
      if (step == 2'd1) begin
        if (st == S_ACKRD) nack_n = sda_s;
        if (st == S_RBIT)  sh_n = {sh[6:0], sda_s};
      end
      if (step != 2'd2) begin
        step_n = step + 2'd1;
      end else begin
        step_n = 2'd0;
        case (st)
          S_START: if (poll) begin st_n = S_WBIT; sh_n = addr; bitn_n = 3'd0; end
                   else begin st_n = S_IDLE; done_n = 1'b1; end
          S_WBIT: begin
            sh_n = {sh[6:0], 1'b0};
            if (bitn == 3'd7) st_n = S_ACKRD;
            else bitn_n = bitn + 3'd1;
          end
          S_ACKRD:
            if (poll && nack && tries != TRY_W'(POLL_MAX)) begin
              st_n = S_START; tries_n = tries + 1'b1;
            end else begin
              st_n = S_IDLE; done_n = 1'b1;
              if (poll && nack) to_n = 1'b1;
            end
          S_RBIT:
            if (bitn == 3'd7) st_n = S_RACK;
            else bitn_n = bitn + 3'd1;
          S_RACK:  begin st_n = S_IDLE; done_n = 1'b1; rx_n = sh; end
          default: begin st_n = S_IDLE; done_n = 1'b1; end
        endcase
      end
    end
  end

  assign dly_start = adv && (st_n != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; step <= 2'd0; bitn <= 3'd0; sh <= '0; addr <= '0;
      poll <= 1'b0; mack <= 1'b0; nack <= 1'b0; timeout <= 1'b0;
      rx_data <= '0; tries <= '0; done <= 1'b0;
      scl_rel <= 1'b1; sda_rel <= 1'b1;
    end else begin
      st <= st_n; step <= step_n; bitn <= bitn_n; sh <= sh_n; addr <= addr_n;
      poll <= poll_n; mack <= mack_n; nack <= nack_n; timeout <= to_n;
      rx_data <= rx_n; tries <= tries_n; done <= done_n;
      if (dly_start) {scl_rel, sda_rel} <= step_lines(st_n, step_n, sh_n[7], mack_n);
    end
  end

  assign busy    = (st != S_IDLE);
  assign in_data = (st == S_WBIT) || (st == S_ACKRD) || (st == S_RBIT) || (st == S_RACK);
endmodule

// File: rtl/i2c_poll_master.sv
module i2c_poll_master #(
  parameter int CYC_PER_UNIT = 25,
  parameter int UNIT_W       = 8,
  parameter int POLL_MAX     = 150,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  input  logic              cmd_ack,
  input  logic [UNIT_W-1:0] dly_units,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rx_data,
  output logic              nack,
  output logic              timeout
);
  logic sda_s, tick, dly_start, scl_rel, sda_rel, in_data;

  i2cm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

  i2cm_delay #(.CYC_PER_UNIT(CYC_PER_UNIT), .UNIT_W(UNIT_W)) u_dly (
    .clk(clk), .rst(rst), .start(dly_start), .units(dly_units), .tick(tick));

  i2cm_seq #(.POLL_MAX(POLL_MAX)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ack(cmd_ack), .tick(tick), .sda_s(sda_s),
    .dly_start(dly_start), .scl_rel(scl_rel), .sda_rel(sda_rel),
    .busy(busy), .done(done), .rx_data(rx_data), .nack(nack),
    .timeout(timeout), .in_data(in_data));

  assign scl_oe = ~scl_rel;
  assign sda_oe = ~sda_rel;
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic nack,
  input logic timeout,
  input logic scl_oe,
  input logic sda_oe,
  input logic in_data
);
  p_sda_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (in_data && $past(in_data) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  p_timeout_nack_r8: assert property (@(posedge clk) disable iff (rst)
    timeout |-> nack);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> ($stable(scl_oe) && $stable(sda_oe)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_on_fall_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind i2c_poll_master i2cm_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .nack(nack),
  .timeout(timeout), .scl_oe(scl_oe), .sda_oe(sda_oe), .in_data(in_data));

// File: tb/tb_i2c_poll_master.sv
module tb_i2c_poll_master;
  localparam int CYC  = 2;
  localparam int PMAX = 150;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ack = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic [7:0] dly_units = 8'd3;
  logic scl_oe, sda_oe, busy, done, nack, timeout;
  logic [7:0] rx_data;

  // target model
  logic rd = 1'b0, sack = 1'b0;
  logic [7:0] tx = 8'd0, cap = 8'd0;
  logic mack_seen = 1'b0;
  int bitc = -2, starts = 0, nack_starts = -1;
  wire scl_bus = ~scl_oe;
  wire sl_pull = rd ? (bitc >= 0 && bitc < 8 && !tx[7 - bitc])
                    : (bitc == 8 && sack && (starts > nack_starts));
  wire sda_bus = ~sda_oe & ~sl_pull;

  always #10 clk = ~clk;

  i2c_poll_master #(.CYC_PER_UNIT(CYC), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ack(cmd_ack), .dly_units(dly_units),
    .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .done(done), .rx_data(rx_data), .nack(nack), .timeout(timeout));

  always @(negedge sda_bus) if (scl_bus) begin starts = starts + 1; bitc = -1; end
  always @(posedge scl_bus) begin
    if (bitc >= 0 && bitc < 8) cap = {cap[6:0], sda_bus};
    else if (bitc == 8) mack_seen = sda_bus;
  end
  always @(negedge scl_bus) if (bitc >= -1) bitc = (bitc == 8) ? 0 : bitc + 1;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic a);
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_ack = a; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 60000) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [2:0] op; logic [7:0] data; logic rdm; logic [7:0] txb;
    logic sak; logic mak; logic enack; logic [7:0] erx; logic [5:0] steps;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{3'd3, 8'hA5, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 6'd27},
    '{3'd3, 8'h3C, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 6'd27},
    '{3'd3, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 6'd27},
    '{3'd4, 8'h00, 1'b1, 8'h96, 1'b0, 1'b0, 1'b0, 8'h96, 6'd27},
    '{3'd4, 8'h00, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 8'h5A, 6'd27},
    '{3'd4, 8'h00, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b0, 8'hC3, 6'd27}
  };

  initial begin
    int n, s0, S;
    S = 3 * CYC;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 lines in reset", {scl_oe, sda_oe}, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 after reset", {busy, done, scl_oe, sda_oe}, 0);

    // R2 start
    s0 = starts;
    issue(3'd1, 8'h00, 1'b0);
    chk("R10 busy after accept", busy, 1);
    wait_done(n);
    chk("R9 start length", n, 3 * S);
    chk("R2 start lines low", {scl_oe, sda_oe}, 2'b11);
    chk("R2 start seen on bus", starts - s0, 1);
    @(posedge clk); @(negedge clk);
    chk("R11 done one cycle", done, 0);

    // table of byte transfers
    for (int i = 0; i < 6; i++) begin
      rd = TBL[i].rdm; tx = TBL[i].txb; sack = TBL[i].sak; nack_starts = -1;
      issue(TBL[i].op, TBL[i].data, TBL[i].mak);
      wait_done(n);
      chk($sformatf("R9 vec%0d length", i), n, TBL[i].steps * S);
      if (TBL[i].op == 3'd3) begin
        chk($sformatf("R4 vec%0d bits on bus", i), cap, TBL[i].data);
        chk($sformatf("R5 vec%0d ack status", i), nack, TBL[i].enack);
      end else begin
        chk($sformatf("R6 vec%0d rx byte", i), rx_data, TBL[i].erx);
        chk($sformatf("R6 vec%0d master ack", i), mack_seen, TBL[i].mak);
      end
    end
    rd = 1'b0;

    // R3 stop
    issue(3'd2, 8'h00, 1'b0);
    wait_done(n);
    chk("R9 stop length", n, 3 * S);
    chk("R3 stop releases", {scl_oe, sda_oe}, 2'b00);

    // R10 unused codes ignored
    issue(3'd6, 8'hFF, 1'b0);
    chk("R10 code 6 ignored", {busy, scl_oe, sda_oe}, 0);
    issue(3'd0, 8'hFF, 1'b0);
    chk("R10 code 0 ignored", {busy, scl_oe, sda_oe}, 0);

    // R9 delay setting
    dly_units = 8'd0;
    issue(3'd1, 8'h00, 1'b0);
    wait_done(n);
    chk("R9 zero units acts as one", n, 3 * CYC);
    dly_units = 8'd5;
    issue(3'd2, 8'h00, 1'b0);
    wait_done(n);
    chk("R9 five units", n, 3 * 5 * CYC);
    dly_units = 8'd3;
    issue(3'd1, 8'h00, 1'b0);
    wait_done(n);

    // R10 command while busy ignored
    sack = 1'b1;
    issue(3'd3, 8'h81, 1'b0);
    repeat (10) @(negedge clk);
    cmd_op = 3'd4; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(n);
    chk("R10 busy write length", n + 11, 27 * S);
    chk("R10 busy write bits", cap, 8'h81);
    repeat (4) @(negedge clk);
    chk("R10 no second command", busy, 0);

    // R7 poll with three refusals
    s0 = starts; nack_starts = starts + 3;
    issue(3'd5, 8'hA0, 1'b0);
    wait_done(n);
    chk("R7 poll length", n, 4 * 30 * S);
    chk("R7 poll attempts", starts - s0, 4);
    chk("R7 poll acked", {timeout, nack}, 2'b00);
    chk("R7 poll address", cap, 8'hA0);

    // R8 poll timeout
    s0 = starts; nack_starts = 1000000;
    issue(3'd5, 8'hA2, 1'b0);
    wait_done(n);
    chk("R8 timeout length", n, PMAX * 30 * S);
    chk("R8 attempts", starts - s0, PMAX);
    chk("R8 flags", {timeout, nack}, 2'b11);

    // R8 cleared by next poll
    nack_starts = -1;
    issue(3'd5, 8'hA2, 1'b0);
    wait_done(n);
    chk("R8 cleared", {timeout, nack}, 2'b00);
    chk("R7 single attempt length", n, 30 * S);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule